// File: doc/BRIEF.md
# Output-First Virtual-Channel Allocator

This block hands free output virtual channels to input virtual channels that are starting a new packet in a router with `P` ports and `V` virtual channels per port. Each input VC presents one request: a valid bit, a one-hot field naming the output port picked by route computation, and a mask of the VCs on that port it will accept. The block compares these requests with its own table of which output VCs are free and returns at most one output VC to each input VC.

The allocator works output-first and is separable. In the first stage every eligible request goes straight to a round-robin arbiter owned by each output VC it could use. Each of these arbiters picks one input VC. Because an input VC may win several output VCs in the same cycle, a second round-robin arbiter for each input VC then keeps exactly one of its wins.

An output VC that is kept is marked busy. It stays busy until the downstream logic frees it through the release input. An output VC that was won and then dropped stays free for later cycles. Grants come out of registers one clock after the request is sampled.

Top module: `vc_allocator`

## Requirements
- R1: While reset is high and in the cycle after it, every output VC reads as free (`vc_avail` all ones) and no grant is valid.
- R2: Input VC `i = port*V + vc` has its request in bit `i` of `req_valid`, its port field in `req_port[i*P +: P]` and its VC mask in `req_vc_mask[i*V +: V]`. Output VC `o = p*V + v` is flag bit `o` of `vc_avail` and `vc_release`. Input VC `i` may be granted output VC `o` only when, at the preceding clock edge, bit `i` of `req_valid` was set, the decoded port was `p`, mask bit `v` was set and `vc_avail[o]` was 1. The grant appears one cycle after the request is sampled. It shows as `gnt_valid[i]`, with `gnt_port[i*PW +: PW] = p` and `gnt_vc[i*VW +: VW] = v` in binary.
- R3: In any cycle, no output VC is granted to more than one input VC.
- R4: An output VC's flag reads 0 in the same cycle its grant becomes visible. Only a grant can clear it, and it stays 0 until released.
- R5: Asserting `vc_release[o]` makes output VC `o` free from the next cycle on. If that output VC is also allocated at the same edge, the allocation wins and the flag stays 0.
- R6: Each output VC arbitrates round-robin among eligible input VCs. The search starts at the index just after the last input VC that kept this output VC.
- R7: Each input VC chooses round-robin among the output VCs it won on its port. The search starts at the VC just after the last one it kept.
- R8: An output VC that wins an input VC in the first stage but is dropped in the second stage stays free. Its round-robin position does not move.
- R9: Whenever at least one request is eligible for at least one free output VC, at least one grant is issued in the next cycle.
- R10: When several bits of a port field are set, only the lowest set bit counts. A request with an all-zero port field is ignored. When `gnt_valid[i]` is 0, the port and VC fields of input VC `i` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | P*V | One request bit per input VC |
| req_port | input | P*V*P | One-hot requested output port, P bits per input VC |
| req_vc_mask | input | P*V*V | Acceptable VCs on the requested port, V bits per input VC |
| vc_release | input | P*V | Frees the matching output VC from the next cycle |
| vc_avail | output | P*V | Free flag of each output VC |
| gnt_valid | output | P*V | Registered grant valid per input VC |
| gnt_port | output | P*V*PW | Granted output port per input VC, PW = max(1, clog2(P)) |
| gnt_vc | output | P*V*VW | Granted VC index per input VC, VW = max(1, clog2(V)) |

## Verification
The bench builds the allocator with three ports and two VCs per port, giving six input VCs and six output VCs. Six is not a power of two, so the round-robin pointers of the output-VC arbiters must wrap explicitly rather than by counter overflow. Three ports let a port field with several bits set test the lowest-bit decode. Two VCs per port are enough for one input VC to win two output VCs at once, which drives the second stage, the drop of an unused winner and the input-side rotation. A long random phase with random releases then covers contention between several input VCs for the same output VC.

// File: rtl/vca_pkg.sv
package vca_pkg;

  // Width of an index into n items, never below one bit.
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Round-robin successor of idx among n positions.
  function automatic int rr_next(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb
  import vca_pkg::*;
#(
  parameter int N = 4
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);

  localparam int IW = idx_w(N);

  logic [IW-1:0] ptr_q;
  int            win;
  int            idx;

  // Scan from the pointer upward with wrap; the first requester wins.
  always_comb begin
    gnt = '0;
    win = -1;
    idx = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (win < 0 && req[idx]) win = idx;
    end
    if (win >= 0) gnt[win] = 1'b1;
  end

  // The pointer moves past the winner only when the caller confirms the grant.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv && win >= 0) begin
      ptr_q <= IW'(rr_next(win, N));
    end
  end

endmodule

// File: rtl/vca_avail_track.sv
module vca_avail_track #(
  parameter int N = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] free_set,
  input  logic [N-1:0] take_clr,
  output logic [N-1:0] avail
);

  // Reset frees every VC; a take in the same edge as a free keeps it busy.
  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= '1;
    end else begin
      avail <= (avail | free_set) & ~take_clr;
    end
  end

endmodule

// File: rtl/vc_allocator.sv
module vc_allocator
  import vca_pkg::*;
#(
  parameter int P = 4,
  parameter int V = 2
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [P*V-1:0]             req_valid,
  input  logic [P*V*P-1:0]           req_port,
  input  logic [P*V*V-1:0]           req_vc_mask,
  input  logic [P*V-1:0]             vc_release,
  output logic [P*V-1:0]             vc_avail,
  output logic [P*V-1:0]             gnt_valid,
  output logic [P*V*idx_w(P)-1:0]    gnt_port,
  output logic [P*V*idx_w(V)-1:0]    gnt_vc
);

  localparam int N  = P * V;
  localparam int PW = idx_w(P);
  localparam int VW = idx_w(V);

  logic [PW-1:0] pidx     [N];
  logic [N-1:0]  has_port;
  logic [N-1:0]  cand     [N];   // cand[o][i]: input VC i eligible for output VC o
  logic [N-1:0]  s1_gnt   [N];   // s1_gnt[o][i]: output VC o picked input VC i
  logic [V-1:0]  won      [N];   // won[i][v]: input VC i picked by VC v of its port
  logic [V-1:0]  s2_gnt   [N];
  logic [VW-1:0] s2_idx   [N];
  logic [N-1:0]  alloc;

  // Port decode: the lowest set bit of each port field is honoured.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      pidx[i]     = '0;
      has_port[i] = 1'b0;
      for (int p = P - 1; p >= 0; p--) begin
        if (req_port[i*P + p]) begin
          pidx[i]     = PW'(p);
          has_port[i] = 1'b1;
        end
      end
    end
  end

  // Eligibility matrix seen by the output-VC arbiters.
  always_comb begin
    for (int o = 0; o < N; o++) begin
      for (int i = 0; i < N; i++) begin
        cand[o][i] = req_valid[i] & has_port[i] & (pidx[i] == PW'(o / V))
                   & req_vc_mask[i*V + (o % V)] & vc_avail[o];
      end
    end
  end

  // Stage one: one arbiter per output VC over all input VCs.
  for (genvar o = 0; o < N; o++) begin : g_out_arb
    vca_rr_arb #(.N(N)) u_out_arb (
      .clk (clk),
      .rst (rst),
      .req (cand[o]),
      .adv (alloc[o]),
      .gnt (s1_gnt[o])
    );
  end

  // Gather the wins of each input VC on its own port.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int v = 0; v < V; v++) begin
        won[i][v] = has_port[i] & s1_gnt[int'(pidx[i]) * V + v][i];
      end
    end
  end

  // Stage two: one arbiter per input VC over the VCs of its port.
  for (genvar i = 0; i < N; i++) begin : g_in_arb
    vca_rr_arb #(.N(V)) u_in_arb (
      .clk (clk),
      .rst (rst),
      .req (won[i]),
      .adv (1'b1),
      .gnt (s2_gnt[i])
    );
  end

  // Encode stage-two choices and mark the output VCs actually taken.
  always_comb begin
    alloc = '0;
    for (int i = 0; i < N; i++) begin
      s2_idx[i] = '0;
      for (int v = 0; v < V; v++) begin
        if (s2_gnt[i][v]) begin
          s2_idx[i] = VW'(v);
          alloc[int'(pidx[i]) * V + v] = 1'b1;
        end
      end
    end
  end

  vca_avail_track #(.N(N)) u_avail (
    .clk      (clk),
    .rst      (rst),
    .free_set (vc_release),
    .take_clr (alloc),
    .avail    (vc_avail)
  );

  // Registered grant outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= '0;
      gnt_port  <= '0;
      gnt_vc    <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        gnt_valid[i]           <= |s2_gnt[i];
        gnt_port[i*PW +: PW]   <= (|s2_gnt[i]) ? pidx[i] : '0;
        gnt_vc[i*VW +: VW]     <= (|s2_gnt[i]) ? s2_idx[i] : '0;
      end
    end
  end

endmodule

// File: rtl/vca_checker.sv
module vca_checker
  import vca_pkg::*;
#(
  parameter int P = 4,
  parameter int V = 2
)(
  input logic                    clk,
  input logic                    rst,
  input logic [P*V-1:0]          req_valid,
  input logic [P*V*P-1:0]        req_port,
  input logic [P*V*V-1:0]        req_vc_mask,
  input logic [P*V-1:0]          vc_release,
  input logic [P*V-1:0]          vc_avail,
  input logic [P*V-1:0]          gnt_valid,
  input logic [P*V*idx_w(P)-1:0] gnt_port,
  input logic [P*V*idx_w(V)-1:0] gnt_vc
);

  localparam int N  = P * V;
  localparam int PW = idx_w(P);
  localparam int VW = idx_w(V);

  logic         seen_q = 1'b0;
  logic [N-1:0] owners [N];   // owners[o][i]: port outputs say i holds o
  logic [N-1:0] elig   [N];   // elig[o][i]: request pattern allows i on o
  int           lp     [N];

  always_ff @(posedge clk) seen_q <= 1'b1;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lp[i] = -1;
      for (int p = P - 1; p >= 0; p--) begin
        if (req_port[i*P + p]) lp[i] = p;
      end
    end
    for (int o = 0; o < N; o++) begin
      for (int i = 0; i < N; i++) begin
        owners[o][i] = gnt_valid[i] && (gnt_port[i*PW +: PW] == PW'(o / V))
                     && (gnt_vc[i*VW +: VW] == VW'(o % V));
        elig[o][i]   = req_valid[i] && (lp[i] == o / V)
                     && req_vc_mask[i*V + (o % V)] && vc_avail[o];
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    (seen_q && $past(rst)) |-> (vc_avail == '1 && gnt_valid == '0));

  for (genvar o = 0; o < N; o++) begin : g_out
    assert_one_owner_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(owners[o]));

    assert_taken_busy_R4: assert property (@(posedge clk) disable iff (rst)
      (|owners[o]) |-> !vc_avail[o]);

    assert_clear_needs_grant_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(vc_avail[o]) |-> (|owners[o]));

    assert_release_frees_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(vc_release[o]) && !(|owners[o])) |-> vc_avail[o]);

    for (genvar i = 0; i < N; i++) begin : g_in
      assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        owners[o][i] |-> $past(elig[o][i]));
    end
  end

endmodule

bind vc_allocator vca_checker #(.P(P), .V(V)) u_vca_checker (.*);

// File: tb/tb_vc_allocator.sv
`timescale 1ns/1ps
module tb_vc_allocator;

  localparam int P  = 3;
  localparam int V  = 2;
  localparam int N  = P * V;
  localparam int PW = 2;
  localparam int VW = 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     req_valid = '0;
  logic [N*P-1:0]   req_port = '0;
  logic [N*V-1:0]   req_vc_mask = '0;
  logic [N-1:0]     vc_release = '0;
  logic [N-1:0]     vc_avail;
  logic [N-1:0]     gnt_valid;
  logic [N*PW-1:0]  gnt_port;
  logic [N*VW-1:0]  gnt_vc;

  vc_allocator #(.P(P), .V(V)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .req_vc_mask(req_vc_mask), .vc_release(vc_release), .vc_avail(vc_avail),
    .gnt_valid(gnt_valid), .gnt_port(gnt_port), .gnt_vc(gnt_vc)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state.
  int optr [N];
  int iptr [N];
  bit m_avail [N];
  bit e_gv [N];
  int e_gp [N];
  int e_gvc [N];
  bit m_any = 1'b0;

  task automatic check(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  function automatic int port_of(int i);
    for (int p = 0; p < P; p++) if (req_port[i*P + p]) return p;
    return -1;
  endfunction

  task automatic model_update();
    int win [N];
    bit nav [N];
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        optr[k] = 0; iptr[k] = 0; m_avail[k] = 1'b1;
        e_gv[k] = 1'b0; e_gp[k] = 0; e_gvc[k] = 0;
      end
      m_any = 1'b0;
      return;
    end
    m_any = 1'b0;
    for (int o = 0; o < N; o++) begin
      win[o] = -1;
      for (int k = 0; k < N; k++) begin
        int i;
        i = (optr[o] + k) % N;
        if (req_valid[i] && port_of(i) == o / V && req_vc_mask[i*V + o % V] && m_avail[o]) begin
          win[o] = i;
          break;
        end
      end
      if (win[o] >= 0) m_any = 1'b1;
      nav[o] = m_avail[o] | vc_release[o];
    end
    for (int i = 0; i < N; i++) begin
      int pt;
      int pick;
      pt = port_of(i);
      pick = -1;
      if (pt >= 0) begin
        for (int k = 0; k < V; k++) begin
          int v;
          v = (iptr[i] + k) % V;
          if (win[pt*V + v] == i) begin
            pick = v;
            break;
          end
        end
      end
      if (pick >= 0) begin
        e_gv[i] = 1'b1; e_gp[i] = pt; e_gvc[i] = pick;
        iptr[i] = (pick + 1) % V;
        optr[pt*V + pick] = (i + 1) % N;
        nav[pt*V + pick] = 1'b0;
      end else begin
        e_gv[i] = 1'b0; e_gp[i] = 0; e_gvc[i] = 0;
      end
    end
    for (int o = 0; o < N; o++) m_avail[o] = nav[o];
  endtask

  task automatic compare();
    int exp_av;
    int cnt;
    for (int i = 0; i < N; i++) begin
      int a;
      int e;
      a = int'(gnt_valid[i]) * 100 + int'(gnt_port[i*PW +: PW]) * 10 + int'(gnt_vc[i*VW +: VW]);
      e = int'(e_gv[i]) * 100 + e_gp[i] * 10 + e_gvc[i];
      check(a == e, cur_req, $sformatf("grant of input VC %0d (valid*100+port*10+vc)", i), a, e);
    end
    exp_av = 0;
    for (int o = 0; o < N; o++) if (m_avail[o]) exp_av = exp_av | (1 << o);
    check(int'(vc_avail) == exp_av, "R4", "availability flags", int'(vc_avail), exp_av);
    for (int o = 0; o < N; o++) begin
      cnt = 0;
      for (int i = 0; i < N; i++)
        if (gnt_valid[i] && int'(gnt_port[i*PW +: PW]) == o / V && int'(gnt_vc[i*VW +: VW]) == o % V) cnt++;
      if (cnt > 1) check(1'b0, "R3", $sformatf("holders of output VC %0d", o), cnt, 1);
    end
    if (m_any) check(gnt_valid != '0, "R9", "grant issued while a request was eligible", int'(gnt_valid != '0), 1);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic clear_inputs();
    req_valid = '0; req_port = '0; req_vc_mask = '0; vc_release = '0;
  endtask

  task automatic set_req(int i, logic [P-1:0] pv, logic [V-1:0] m);
    req_valid[i] = 1'b1;
    req_port[i*P +: P] = pv;
    req_vc_mask[i*V +: V] = m;
  endtask

  task automatic expect_grant(int i, bit v, int p, int c, string r);
    int a;
    int e;
    a = int'(gnt_valid[i]) * 100 + int'(gnt_port[i*PW +: PW]) * 10 + int'(gnt_vc[i*VW +: VW]);
    e = int'(v) * 100 + p * 10 + c;
    check(a == e, r, $sformatf("hand-computed grant of input VC %0d", i), a, e);
  endtask

  task automatic expect_avail(int o, bit a, string r);
    check(vc_avail[o] == a, r, $sformatf("flag of output VC %0d", o), int'(vc_avail[o]), int'(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    clear_inputs();
    repeat (3) step();
    @(negedge clk) rst = 1'b0;
    step();
    check(vc_avail == '1, "R1", "flags after reset", int'(vc_avail), (1 << N) - 1);
    check(gnt_valid == '0, "R1", "grants after reset", int'(gnt_valid), 0);

    // R2: single request, port 1, both VCs acceptable -> output VC 2
    cur_req = "R2";
    set_req(0, 3'b010, 2'b11);
    step();
    expect_grant(0, 1'b1, 1, 0, "R2");
    expect_avail(2, 1'b0, "R4");
    clear_inputs();
    step();
    expect_avail(2, 1'b0, "R4");
    vc_release[2] = 1'b1;
    step();
    vc_release = '0;
    expect_avail(2, 1'b1, "R5");

    // R6: three inputs contend for output VC 4 (port 2, VC 0)
    cur_req = "R6";
    set_req(1, 3'b100, 2'b01);
    set_req(2, 3'b100, 2'b01);
    set_req(3, 3'b100, 2'b01);
    step();
    expect_grant(1, 1'b1, 2, 0, "R6");
    expect_grant(2, 1'b0, 0, 0, "R10");
    req_valid[1] = 1'b0;
    vc_release[4] = 1'b1;
    step();
    vc_release = '0;
    expect_grant(2, 1'b0, 0, 0, "R5");
    expect_avail(4, 1'b1, "R5");
    step();
    expect_grant(2, 1'b1, 2, 0, "R6");
    req_valid[2] = 1'b0;
    vc_release[4] = 1'b1;
    step();
    vc_release = '0;
    step();
    expect_grant(3, 1'b1, 2, 0, "R6");
    clear_inputs();
    vc_release[4] = 1'b1;
    step();
    vc_release = '0;

    // R7/R8: input VC 4 wins both VCs of port 0, keeps VC 0, VC 1 stays free
    cur_req = "R8";
    set_req(4, 3'b001, 2'b11);
    set_req(5, 3'b001, 2'b11);
    step();
    expect_grant(4, 1'b1, 0, 0, "R7");
    expect_grant(5, 1'b0, 0, 0, "R8");
    expect_avail(1, 1'b1, "R8");
    req_valid[4] = 1'b0;
    step();
    expect_grant(5, 1'b1, 0, 1, "R8");
    clear_inputs();
    vc_release[0] = 1'b1;
    vc_release[1] = 1'b1;
    step();
    vc_release = '0;

    // R7: input VC 0 last kept VC 0, so with both free it now keeps VC 1
    cur_req = "R7";
    set_req(0, 3'b001, 2'b11);
    step();
    expect_grant(0, 1'b1, 0, 1, "R7");
    expect_avail(0, 1'b1, "R7");
    clear_inputs();
    vc_release[1] = 1'b1;
    step();
    vc_release = '0;

    // R5: allocation and release of output VC 5 in the same edge
    cur_req = "R5";
    set_req(1, 3'b100, 2'b10);
    vc_release[5] = 1'b1;
    step();
    expect_grant(1, 1'b1, 2, 1, "R5");
    expect_avail(5, 1'b0, "R5");
    clear_inputs();
    vc_release[5] = 1'b1;
    step();
    vc_release = '0;

    // R10: port field 110 decodes as port 1; all-zero port field is ignored
    cur_req = "R10";
    set_req(2, 3'b110, 2'b01);
    set_req(3, 3'b000, 2'b11);
    step();
    expect_grant(2, 1'b1, 1, 0, "R10");
    expect_grant(3, 1'b0, 0, 0, "R10");
    clear_inputs();
    vc_release[2] = 1'b1;
    step();
    vc_release = '0;

    // R9: random traffic with random releases against the reference model
    cur_req = "R9";
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int i = 0; i < N; i++) begin
        int r;
        r = int'($urandom % 6);
        if (r < 2) set_req(i, P'(1 << ($urandom % P)), V'(($urandom % ((1 << V) - 1)) + 1));
        else if (r < 4) req_valid[i] = 1'b0;
      end
      for (int o = 0; o < N; o++) vc_release[o] = ($urandom % 4) == 0;
      step();
    end
    clear_inputs();
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule